// File: doc/BRIEF.md
# PCIe TLP Trace Capture Filter

This block sits beside a PCIe core's packet path and decides, one header per cycle, whether an observed transaction-layer packet header should be handed to a trace capture engine. Each observed header comes with the index of the root port it was seen on, a flag for whether it travels outbound (towards the link) or inbound, and a flag that marks a completion as belonging to the DMA-remote-to-local / peer-to-peer sub-class ("class B"). Every other completion is "class A".

The capture decision combines three configuration inputs. A 20-bit filter word selects either a multi-port source mask or a single exact requester ID. An 8-bit type mask selects among posted, non-posted and completion packets. A 4-bit direction code picks which flows are kept. The direction codes mean different things in the two filter modes. One cycle after a header is offered, the block raises a capture strobe and presents the header unchanged. It also reports, through a registered flag, a configuration that can never capture anything.

Top module: `tlp_trace_filter`

## Requirements
- R1: When filter bit 19 is 1 (port mode), a header passes the source check only if bit `port_idx` of filter bits 15:0 is set. Any number of ports may be selected together.
- R2: When filter bit 19 is 0 (requester mode), a header passes the source check only if its requester ID equals filter bits 15:0 exactly. For requests that ID is header bits 63:48 (DW1 upper half). For completions it is header bits 95:80 (DW2 upper half).
- R3: Filter bits 18:16 have no effect on any output.
- R4: A header passes the type check only if its class bit is set in the type mask: bit 0 for posted, bit 1 for non-posted, bit 2 for completions. Type mask bits 7:3 have no effect.
- R5: Class is decoded from header bits 31:29 (fmt) and 28:24 (type). Type 0101x is a completion. Type 00000 with fmt bit 1 set (memory write) is posted, as is any type 10xxx (message). Everything else is non-posted. The `cpl_b` flag matters only for completions.
- R6: In port mode, direction code 0 keeps all inbound packets. Code 1 keeps all outbound packets. Code 2 keeps all outbound packets plus inbound posted, non-posted and class-B completions. Code 3 keeps all outbound packets plus inbound class-A completions only.
- R7: In requester mode, direction code 1 keeps all outbound packets. Code 2 keeps inbound posted, non-posted and class-B completions only. Code 3 keeps inbound class-A completions only.
- R8: Direction codes 4 to 15 in either mode, and code 0 in requester mode, capture nothing. They set `cfg_err` one cycle after they are applied. Legal codes clear it one cycle later.
- R9: `cap_valid` rises in the cycle after a header is offered with `hdr_valid` high and all checks pass. `cap_hdr` then equals that header bit for bit. No capture follows a cycle with `hdr_valid` low.
- R10: While `rst` is high, `cap_valid` and `cfg_err` are 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A header is offered this cycle |
| hdr | input | 128 | Four-DW TLP header, DW0 in bits 31:0 |
| port_idx | input | 4 | Root port index the header was seen on |
| outbound | input | 1 | 1 = outbound packet, 0 = inbound |
| cpl_b | input | 1 | Completion belongs to class B |
| cfg_filter | input | 20 | Bit 19 mode, bits 15:0 port mask or requester ID |
| cfg_type | input | 8 | Packet class enable mask |
| cfg_dir | input | 4 | Direction selection code |
| cap_valid | output | 1 | Registered capture strobe |
| cap_hdr | output | 128 | Header being captured |
| cfg_err | output | 1 | Registered illegal direction configuration flag |

## Verification
The direction tables are swept over every legal code and several illegal ones, in both filter modes. Each sweep crosses inbound and outbound packets with posted, non-posted, class-A and class-B completion headers, so a swapped table entry or a misread sub-class shows up as a single wrong capture. Source matching uses a sparse port mask across all port indices, plus requester IDs that differ by one bit. Completions carry a decoy ID in the request position, which separates correct field selection from reading the wrong DW. Reserved filter bits, high type-mask bits and a stray `cpl_b` on requests are toggled with everything else fixed, and idle cycles are mixed into back-to-back traffic to show that captures line up with offered headers.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;

  // Configuration word layout
  localparam int FILT_W        = 20;
  localparam int FILT_MODE_BIT = 19;
  localparam int FILT_VAL_W    = 16;
  localparam int TYPE_MASK_W   = 8;
  localparam int DIR_CODE_W    = 4;
  localparam int RID_W         = 16;

  // Packet class, also the bit index in the type mask
  typedef enum logic [1:0] {
    CLS_P   = 2'd0,
    CLS_NP  = 2'd1,
    CLS_CPL = 2'd2
  } tlp_cls_e;

  // Direction selection codes
  localparam logic [DIR_CODE_W-1:0] DSEL_0 = 4'd0;
  localparam logic [DIR_CODE_W-1:0] DSEL_1 = 4'd1;
  localparam logic [DIR_CODE_W-1:0] DSEL_2 = 4'd2;
  localparam logic [DIR_CODE_W-1:0] DSEL_3 = 4'd3;

endpackage

// File: rtl/tlp_classify.sv
module tlp_classify
  import tlp_trace_pkg::*;
(
  input  logic [7:0]       dw0_top,   // fmt[2:0], type[4:0]
  input  logic [RID_W-1:0] id_dw1,    // requester ID position of a request
  input  logic [RID_W-1:0] id_dw2,    // requester ID position of a completion
  output tlp_cls_e         cls,
  output logic [RID_W-1:0] rid
);

  logic [2:0] fmt;
  logic [4:0] typ;
  logic       unused_fmt_bits;

  assign fmt = dw0_top[7:5];
  assign typ = dw0_top[4:0];
  assign unused_fmt_bits = ^{fmt[2], fmt[0]};

  always_comb begin
    if (typ[4:1] == 4'b0101) begin
      cls = CLS_CPL;
    end else if ((typ == 5'b00000 && fmt[1]) || typ[4:3] == 2'b10) begin
      cls = CLS_P;
    end else begin
      cls = CLS_NP;
    end
  end

  assign rid = (cls == CLS_CPL) ? id_dw2 : id_dw1;

endmodule

// File: rtl/trace_src_match.sv
module trace_src_match
  import tlp_trace_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  port_mode,
  input  logic [FILT_VAL_W-1:0] value,
  input  logic [PORT_W-1:0]     port_idx,
  input  logic [RID_W-1:0]      rid,
  output logic                  hit
);

  logic [NUM_PORTS-1:0] port_sel;
  logic                 port_hit;
  logic                 rid_hit;

  // One comparator per port, gated by its mask bit
  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_port
      assign port_sel[g] = value[g] && (port_idx == PORT_W'(g));
    end
  endgenerate

  assign port_hit = |port_sel;
  assign rid_hit  = (rid == value[RID_W-1:0]);
  assign hit      = port_mode ? port_hit : rid_hit;

endmodule

// File: rtl/trace_dir_gate.sv
module trace_dir_gate
  import tlp_trace_pkg::*;
(
  input  logic                  port_mode,
  input  logic [DIR_CODE_W-1:0] dir_code,
  input  logic                  outbound,
  input  tlp_cls_e              cls,
  input  logic                  cpl_b,
  output logic                  allow,
  output logic                  bad_code
);

  logic in_set_b;   // inbound posted, non-posted or class-B completion
  logic in_set_a;   // inbound class-A completion

  assign in_set_b = !outbound && ((cls != CLS_CPL) || cpl_b);
  assign in_set_a = !outbound && (cls == CLS_CPL) && !cpl_b;

  always_comb begin
    allow    = 1'b0;
    bad_code = 1'b0;
    if (dir_code > DSEL_3) begin
      bad_code = 1'b1;
    end else if (port_mode) begin
      unique case (dir_code)
        DSEL_0:  allow = !outbound;
        DSEL_1:  allow = outbound;
        DSEL_2:  allow = outbound || in_set_b;
        default: allow = outbound || in_set_a;
      endcase
    end else begin
      unique case (dir_code)
        DSEL_0:  bad_code = 1'b1;
        DSEL_1:  allow = outbound;
        DSEL_2:  allow = in_set_b;
        default: allow = in_set_a;
      endcase
    end
  end

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
  import tlp_trace_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int DW_W      = 32,
  parameter int HDR_DW    = 4,
  localparam int HDR_W  = DW_W * HDR_DW,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hdr_valid,
  input  logic [HDR_W-1:0]       hdr,
  input  logic [PORT_W-1:0]      port_idx,
  input  logic                   outbound,
  input  logic                   cpl_b,
  input  logic [FILT_W-1:0]      cfg_filter,
  input  logic [TYPE_MASK_W-1:0] cfg_type,
  input  logic [DIR_CODE_W-1:0]  cfg_dir,
  output logic                   cap_valid,
  output logic [HDR_W-1:0]       cap_hdr,
  output logic                   cfg_err
);

  tlp_cls_e         cls;
  logic [RID_W-1:0] rid;
  logic             src_hit;
  logic             dir_ok;
  logic             dir_bad;
  logic             type_hit;
  logic             pass_c;
  logic [2:0]       cls_oh;
  logic             port_mode;
  logic             unused_cfg_bits;

  assign port_mode       = cfg_filter[FILT_MODE_BIT];
  assign unused_cfg_bits = ^{cfg_filter[18:16], cfg_type[7:3]};

  tlp_classify u_cls (
    .dw0_top (hdr[31:24]),
    .id_dw1  (hdr[63:48]),
    .id_dw2  (hdr[95:80]),
    .cls     (cls),
    .rid     (rid)
  );

  trace_src_match #(.NUM_PORTS(NUM_PORTS)) u_src (
    .port_mode (port_mode),
    .value     (cfg_filter[FILT_VAL_W-1:0]),
    .port_idx  (port_idx),
    .rid       (rid),
    .hit       (src_hit)
  );

  trace_dir_gate u_dir (
    .port_mode (port_mode),
    .dir_code  (cfg_dir),
    .outbound  (outbound),
    .cls       (cls),
    .cpl_b     (cpl_b),
    .allow     (dir_ok),
    .bad_code  (dir_bad)
  );

  assign cls_oh   = 3'b001 << cls;
  assign type_hit = |(cls_oh & cfg_type[2:0]);
  assign pass_c   = hdr_valid && src_hit && type_hit && dir_ok && !dir_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cfg_err   <= 1'b0;
      cap_hdr   <= '0;
    end else begin
      cap_valid <= pass_c;
      cfg_err   <= dir_bad;
      if (hdr_valid) begin
        cap_hdr <= hdr;
      end
    end
  end

  // Assertions
  logic port_bit_chk;
  assign port_bit_chk = cfg_filter[port_idx];

  AST_CAP_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> $past(hdr_valid));                                         // R9
  AST_HDR_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (cap_hdr == $past(hdr)));                                  // R9
  AST_ERR_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !cap_valid);                                                 // R8
  AST_TYPE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> ($past(cls_oh & cfg_type[2:0]) != 3'b000));                // R4
  AST_PORT_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && $past(cfg_filter[FILT_MODE_BIT])) |-> $past(port_bit_chk)); // R1
  AST_RID_EXACT: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !$past(cfg_filter[FILT_MODE_BIT]))
      |-> ($past(rid) == $past(cfg_filter[FILT_VAL_W-1:0])));                // R2
  AST_REQ_INBOUND_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !$past(cfg_filter[FILT_MODE_BIT]) && ($past(cfg_dir) == DSEL_2))
      |-> !$past(outbound));                                                 // R7

endmodule

// File: tb/sim_tlp_trace_filter.sv
`timescale 1ns/1ps
module sim_tlp_trace_filter;

  localparam int HW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          hdr_valid;
  logic [HW-1:0] hdr;
  logic [3:0]    port_idx;
  logic          outbound;
  logic          cpl_b;
  logic [19:0]   cfg_filter;
  logic [7:0]    cfg_type;
  logic [3:0]    cfg_dir;
  logic          cap_valid;
  logic [HW-1:0] cap_hdr;
  logic          cfg_err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit            v;
    logic [HW-1:0] h;
    bit            e;
    string         tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;   // 250 MHz

  tlp_trace_filter u0 (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr(hdr),
    .port_idx(port_idx), .outbound(outbound), .cpl_b(cpl_b),
    .cfg_filter(cfg_filter), .cfg_type(cfg_type), .cfg_dir(cfg_dir),
    .cap_valid(cap_valid), .cap_hdr(cap_hdr), .cfg_err(cfg_err)
  );

  // kind: 0 posted, 1 non-posted, 2 completion A, 3 completion B
  function automatic logic [HW-1:0] mk_hdr(int kind, logic [15:0] id, logic [15:0] decoy, logic [31:0] salt);
    logic [HW-1:0] h;
    h = {salt, 32'h0, 32'h0, 32'h0000_0010};
    if (kind == 0)      h[31:24] = {3'b011, 5'b00000};
    else if (kind == 1) h[31:24] = {3'b001, 5'b00000};
    else                h[31:24] = {3'b010, 5'b01010};
    if (kind >= 2) begin
      h[95:80] = id;
      h[63:48] = decoy;
    end else begin
      h[63:48] = id;
      h[95:80] = decoy;
    end
    return h;
  endfunction

  function automatic bit model_err(logic [19:0] f, logic [3:0] d);
    if (d >= 4) return 1'b1;
    if (!f[19] && d == 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit model_pass(logic [19:0] f, logic [7:0] tm, logic [3:0] d,
                                    int port, logic [15:0] id, bit outb, int kind);
    bit src, typ, dir, a_cpl, inb;
    if (model_err(f, d)) return 1'b0;
    src   = f[19] ? f[port] : (f[15:0] == id);
    typ   = tm[(kind >= 2) ? 2 : kind];
    inb   = !outb;
    a_cpl = (kind == 2);
    if (f[19]) begin
      case (d)
        4'd0:    dir = inb;
        4'd1:    dir = outb;
        4'd2:    dir = outb || (inb && !a_cpl);
        default: dir = outb || (inb && a_cpl);
      endcase
    end else begin
      case (d)
        4'd1:    dir = outb;
        4'd2:    dir = inb && !a_cpl;
        default: dir = inb && a_cpl;
      endcase
    end
    return src && typ && dir;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(bit hv, int kind, logic [15:0] id, logic [15:0] decoy, int port,
                       bit outb, bit cb, logic [19:0] f, logic [7:0] tm, logic [3:0] d,
                       logic [31:0] salt, string tag);
    exp_t x;
    @(negedge clk);
    hdr_valid  = hv;
    hdr        = mk_hdr(kind, id, decoy, salt);
    port_idx   = port[3:0];
    outbound   = outb;
    cpl_b      = cb;
    cfg_filter = f;
    cfg_type   = tm;
    cfg_dir    = d;
    x.v   = hv && model_pass(f, tm, d, port, id, outb, kind);
    x.h   = hdr;
    x.e   = model_err(f, d);
    x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: compares one queued result per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      checks++;
      if (cap_valid !== x.v || cfg_err !== x.e || (x.v && cap_hdr !== x.h)) begin
        errors++;
        $display("FAIL %s: cap_valid=%0b cfg_err=%0b cap_hdr=%h expected cap_valid=%0b cfg_err=%0b cap_hdr=%h",
                 x.tag, cap_valid, cfg_err, cap_hdr, x.v, x.e, x.h);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion before timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst        = 1'b1;
    hdr_valid  = 1'b1;
    hdr        = mk_hdr(0, 16'h1, 16'h2, 32'h0);
    port_idx   = 4'd0;
    outbound   = 1'b1;
    cpl_b      = 1'b0;
    cfg_filter = 20'h8FFFF;
    cfg_type   = 8'hFF;
    cfg_dir    = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    checks++;   // R10: outputs held low under reset even with an illegal config
    if (cap_valid !== 1'b0 || cfg_err !== 1'b0) begin
      errors++;
      $display("FAIL R10: cap_valid=%0b cfg_err=%0b expected 0 0", cap_valid, cfg_err);
    end
    @(negedge clk);
    rst = 1'b0;

    // R6 / R7 / R8: direction tables across modes, codes, directions and classes
    for (int m = 0; m < 2; m++) begin
      for (int di = 0; di < 7; di++) begin
        logic [3:0] d;
        d = (di < 5) ? di[3:0] : ((di == 5) ? 4'd9 : 4'd15);
        for (int o = 0; o < 2; o++) begin
          for (int k = 0; k < 4; k++) begin
            drive(1'b1, k, 16'h1234, 16'h5678, 3, o[0], (k == 3), m ? 20'h8FFFF : 20'h01234,
                  8'h07, d, 32'(m * 1000 + di * 100 + o * 10 + k),
                  (d >= 4 || (m == 0 && d == 0)) ? "R8" : (m ? "R6" : "R7"));
          end
        end
      end
    end

    // R4 / R5: type mask per class, high bits ignored, cpl_b ignored on requests
    for (int t = 0; t < 6; t++) begin
      logic [7:0] tm;
      tm = (t < 3) ? (8'h01 << t) : ((t == 3) ? 8'h00 : ((t == 4) ? 8'hF8 : 8'hFB));
      for (int k = 0; k < 4; k++) begin
        drive(1'b1, k, 16'h0, 16'h0, 0, 1'b1, (k == 3), 20'h80001, tm, 4'd1,
              32'(t * 10 + k), "R4");
      end
    end
    drive(1'b1, 0, 16'h0, 16'h0, 0, 1'b0, 1'b1, 20'h80001, 8'h07, 4'd3, 32'hB0, "R5");
    drive(1'b1, 1, 16'h0, 16'h0, 0, 1'b0, 1'b1, 20'h80001, 8'h07, 4'd2, 32'hB1, "R5");
    drive(1'b1, 2, 16'h0, 16'h0, 0, 1'b0, 1'b0, 20'h80001, 8'h07, 4'd3, 32'hB2, "R5");
    drive(1'b1, 3, 16'h0, 16'h0, 0, 1'b0, 1'b1, 20'h80001, 8'h07, 4'd3, 32'hB3, "R5");

    // R1: sparse port mask over all port indices
    for (int p = 0; p < 16; p++) begin
      drive(1'b1, 1, 16'h0, 16'h0, p, 1'b1, 1'b0, 20'h88005, 8'h07, 4'd1, 32'(p), "R1");
    end

    // R2: exact requester match, one-bit misses, completion ID field with decoy
    drive(1'b1, 0, 16'hBEEF, 16'h0000, 2, 1'b1, 1'b0, 20'h0BEEF, 8'h07, 4'd1, 32'hC0, "R2");
    drive(1'b1, 0, 16'hBEEE, 16'hBEEF, 2, 1'b1, 1'b0, 20'h0BEEF, 8'h07, 4'd1, 32'hC1, "R2");
    drive(1'b1, 1, 16'h3EEF, 16'hBEEF, 2, 1'b1, 1'b0, 20'h0BEEF, 8'h07, 4'd1, 32'hC2, "R2");
    drive(1'b1, 2, 16'hBEEF, 16'h1111, 2, 1'b0, 1'b0, 20'h0BEEF, 8'h07, 4'd3, 32'hC3, "R2");
    drive(1'b1, 2, 16'h1111, 16'hBEEF, 2, 1'b0, 1'b0, 20'h0BEEF, 8'h07, 4'd3, 32'hC4, "R2");
    drive(1'b1, 3, 16'hBEEF, 16'h1111, 2, 1'b0, 1'b1, 20'h0BEEF, 8'h07, 4'd2, 32'hC5, "R2");

    // R3: reserved filter bits toggled in both modes
    for (int r = 0; r < 8; r++) begin
      drive(1'b1, 0, 16'h0042, 16'h0, 1, 1'b1, 1'b0, {1'b0, r[2:0], 16'h0042}, 8'h07, 4'd1, 32'(r), "R3");
      drive(1'b1, 0, 16'h0042, 16'h0, 1, 1'b1, 1'b0, {1'b1, r[2:0], 16'h0002}, 8'h07, 4'd1, 32'(r + 8), "R3");
      drive(1'b1, 0, 16'h0042, 16'h0, 1, 1'b1, 1'b0, {1'b1, r[2:0], 16'h0001}, 8'h07, 4'd2, 32'(r + 16), "R3");
    end

    // R8: error flag follows config changes, R9: back-to-back with idle gaps
    for (int i = 0; i < 24; i++) begin
      bit hv;
      hv = (i % 3) != 2;
      drive(hv, i % 4, 16'h00A5, 16'h0, i % 16, (i % 2) == 1, ((i % 4) == 3), 20'h8FFFF,
            8'h07, (i % 5 == 4) ? 4'd7 : 4'd2, 32'hDEAD_0000 + 32'(i), (i % 5 == 4) ? "R8" : "R9");
    end
    drive(1'b0, 0, 16'h0, 16'h0, 0, 1'b1, 1'b0, 20'h8FFFF, 8'h07, 4'd1, 32'h0, "R9");

    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule